// File: doc/BRIEF.md
# Script Register Byte-Operation Unit

This unit carries out the register-transfer instructions of a small script processor. It owns a bank of byte-wide registers (96 by default) and an accumulator-like register at a fixed address (8 by default) that acts as the hub for transfers between two registers. Each accepted instruction reads one register, passes the byte through an operator stage (immediate load, shift through carry, OR, XOR, AND, add, add with carry) and writes the result back to one register. A plain copy is expressed as OR with a zero immediate. A single carry flag links chained additions and shifts. Two flag instructions can set or clear that carry without touching any register.

A controller pulses `start` with a 32-bit instruction word. The unit answers with a one-cycle `done` and, at that moment, shows the written byte, its destination address, the carry flag, and whether the instruction was refused as illegal. The instruction word is laid out as follows: class in bits 31:27, operator in bits 26:24, register address in bits 22:16, immediate byte in bits 15:8, and carry select in bit 10 for the flag classes.

Top module: `scr_regalu`

## Requirements
- R1: After reset every register holds 0x00, the carry flag is 0, and `done` and `illegal` are low.
- R2: Class 5'b00111 (in-place) with operator 0 writes the immediate byte (bits 15:8) into the register addressed by bits 22:16.
- R3: In the in-place class, operator 2 (OR), 3 (XOR) and 4 (AND) combine the addressed register with the immediate and write the result back to the same register. The carry flag is left unchanged.
- R4: Class 5'b00110 applies the operator to the addressed register and writes the result into the hub register at address 8. The addressed register keeps its value.
- R5: Class 5'b00101 applies the operator to the hub register at address 8 and writes the result into the addressed register. The hub register keeps its value.
- R6: Operator 6 writes the low byte of register+immediate and loads the carry flag with the carry-out, ignoring the old carry. Operator 7 also adds the old carry as carry-in.
- R7: Operator 1 shifts left: the old carry enters bit 0 and bit 7 moves into the carry. Operator 5 shifts right: the old carry enters bit 7 and bit 0 moves into the carry. The immediate is not used.
- R8: Class 5'b01011 (set) and class 5'b01100 (clear) with bit 10 set force the carry flag to 1 or 0. With bit 10 clear, the carry is unchanged. These classes never write a register.
- R9: An instruction is illegal if its class is not one of the five listed, if a transfer addresses a register at or above the register count, or if operator 0 is used with class 00110 or 00101. An illegal instruction raises `illegal` together with `done`, writes no register, and leaves the carry unchanged.
- R10: `done` is a single-cycle pulse. For a transfer it appears 4 clock edges after the edge that samples `start`. For a flag or illegal instruction it appears after 1 edge. `start` is ignored while an instruction is in progress.
- R11: While `done` is high after a transfer, `resByte` shows the byte that was written and `resAddr` shows the register it went to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept `instr` when the unit is idle |
| instr | input | 32 | Instruction word |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Instruction refused; valid with `done` |
| resByte | output | 8 | Byte written by the last transfer |
| resAddr | output | 7 | Destination register of the last transfer |
| carry | output | 1 | Current carry flag |

## Verification
The register write-back and the carry update land on the same clock edge for additions and shifts. The bench follows an add that overflows directly with an add-with-carry, and a shift-left with a second shift-left, so the second instruction must use the carry produced by the first one. Each value is compared with the arithmetic worked out in the bench. A second collision occurs when `start` stays high, with a different instruction on `instr`, while a transfer is still running. The bench judges this by checking that only the first instruction's destination appears at `done`, and by reading back the second instruction's target through an OR-zero transfer to show that it was never written.

// File: rtl/scr_regalu_pkg.sv
package scr_regalu_pkg;

  localparam int AddrBits = 7;

  localparam logic [4:0] ClsInPlace = 5'b00111;
  localparam logic [4:0] ClsToHub   = 5'b00110;
  localparam logic [4:0] ClsFromHub = 5'b00101;
  localparam logic [4:0] ClsSetFlag = 5'b01011;
  localparam logic [4:0] ClsClrFlag = 5'b01100;

  typedef enum logic [2:0] {
    OpImm  = 3'd0,
    OpShl  = 3'd1,
    OpOr   = 3'd2,
    OpXor  = 3'd3,
    OpAnd  = 3'd4,
    OpShr  = 3'd5,
    OpAdd  = 3'd6,
    OpAddc = 3'd7
  } byteOpE;

  typedef struct packed {
    logic                rdEn;
    logic                calcEn;
    logic                wrEn;
    logic                carryLoad;
    logic                carryVal;
    logic [AddrBits-1:0] rdAddr;
    logic [AddrBits-1:0] wrAddr;
    byteOpE              op;
    logic [7:0]          imm;
  } ctlBusT;

endpackage

// File: rtl/scr_regalu_byteop.sv
module scr_regalu_byteop
  import scr_regalu_pkg::*;
(
  input  byteOpE     op,
  input  logic [7:0] srcByte,
  input  logic [7:0] immByte,
  input  logic       carryIn,
  output logic [7:0] outByte,
  output logic       carryOut,
  output logic       carryTouch
);

  logic [8:0] sumWide;

  always_comb begin
    sumWide = {1'b0, srcByte} + {1'b0, immByte} + {8'b0, (op == OpAddc) & carryIn};
  end

  always_comb begin
    outByte    = srcByte;
    carryOut   = carryIn;
    carryTouch = 1'b0;
    unique case (op)
      OpImm: outByte = immByte;
      OpOr:  outByte = srcByte | immByte;
      OpXor: outByte = srcByte ^ immByte;
      OpAnd: outByte = srcByte & immByte;
      OpShl: begin
        outByte    = {srcByte[6:0], carryIn};
        carryOut   = srcByte[7];
        carryTouch = 1'b1;
      end
      OpShr: begin
        outByte    = {carryIn, srcByte[7:1]};
        carryOut   = srcByte[0];
        carryTouch = 1'b1;
      end
      OpAdd, OpAddc: begin
        outByte    = sumWide[7:0];
        carryOut   = sumWide[8];
        carryTouch = 1'b1;
      end
      default: outByte = srcByte;
    endcase
  end

endmodule

// File: rtl/scr_regalu_dpath.sv
module scr_regalu_dpath
  import scr_regalu_pkg::*;
#(
  parameter int RegCount = 96
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlBusT     ctl,
  output logic [7:0] resByte,
  output logic       carry
);

  logic [7:0] regFile [RegCount];
  logic [7:0] srcQ;
  logic [7:0] resQ;
  logic       carryQ;
  logic       carryNxtQ;
  logic       carryWrQ;
  logic [7:0] opOut;
  logic       opCarry;
  logic       opTouch;

  scr_regalu_byteop uOp (
    .op        (ctl.op),
    .srcByte   (srcQ),
    .immByte   (ctl.imm),
    .carryIn   (carryQ),
    .outByte   (opOut),
    .carryOut  (opCarry),
    .carryTouch(opTouch)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < RegCount; i++) regFile[i] <= '0;
    end else if (ctl.wrEn) begin
      regFile[ctl.wrAddr] <= resQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ      <= '0;
      resQ      <= '0;
      carryNxtQ <= 1'b0;
      carryWrQ  <= 1'b0;
      carryQ    <= 1'b0;
    end else begin
      if (ctl.rdEn) srcQ <= regFile[ctl.rdAddr];
      if (ctl.calcEn) begin
        resQ      <= opOut;
        carryNxtQ <= opCarry;
        carryWrQ  <= opTouch;
      end
      if (ctl.carryLoad) carryQ <= ctl.carryVal;
      else if (ctl.wrEn && carryWrQ) carryQ <= carryNxtQ;
    end
  end

  assign resByte = resQ;
  assign carry   = carryQ;

  a_r9_write_in_range: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrEn |-> (int'(ctl.wrAddr) < RegCount));

  a_r10_write_follows_calc: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrEn |-> $past(ctl.calcEn));

  a_r8_carry_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.wrEn && !ctl.carryLoad) |=> $stable(carryQ));

  a_r10_read_before_calc: assert property (@(posedge clk) disable iff (!rstN)
    ctl.calcEn |-> $past(ctl.rdEn));

endmodule

// File: rtl/scr_regalu_ctrl.sv
module scr_regalu_ctrl
  import scr_regalu_pkg::*;
#(
  parameter int RegCount = 96,
  parameter int HubAddr  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [31:0]         instr,
  output ctlBusT              ctl,
  output logic                done,
  output logic                illegal,
  output logic [AddrBits-1:0] resAddr
);

  typedef enum logic [2:0] {
    StIdle, StRead, StCalc, StWrite, StDone
  } stateE;

  localparam logic [AddrBits-1:0] HubA = AddrBits'(HubAddr);

  stateE               stateQ;
  logic [4:0]          cls;
  byteOpE              opIn;
  logic [AddrBits-1:0] addrIn;
  logic                isMove;
  logic                isFlag;
  logic                badAddr;
  logic                crossImm;
  logic                refuse;
  logic                accept;
  logic [AddrBits-1:0] rdAddrQ;
  logic [AddrBits-1:0] wrAddrQ;
  byteOpE              opQ;
  logic [7:0]          immQ;
  logic                illegalQ;
  logic                unusedBits;

  assign cls        = instr[31:27];
  assign opIn       = byteOpE'(instr[26:24]);
  assign addrIn     = instr[22:16];
  assign unusedBits = ^{instr[23], instr[9:0]};

  always_comb begin
    isMove   = (cls == ClsInPlace) || (cls == ClsToHub) || (cls == ClsFromHub);
    isFlag   = (cls == ClsSetFlag) || (cls == ClsClrFlag);
    badAddr  = int'(addrIn) >= RegCount;
    crossImm = (opIn == OpImm) && (cls != ClsInPlace);
    refuse   = !(isMove || isFlag) || (isMove && (badAddr || crossImm));
    accept   = start && (stateQ == StIdle);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= StIdle;
      rdAddrQ  <= '0;
      wrAddrQ  <= '0;
      opQ      <= OpImm;
      immQ     <= '0;
      illegalQ <= 1'b0;
    end else begin
      unique case (stateQ)
        StIdle: begin
          if (accept) begin
            illegalQ <= refuse;
            if (refuse || isFlag) begin
              stateQ <= StDone;
            end else begin
              stateQ  <= StRead;
              rdAddrQ <= (cls == ClsFromHub) ? HubA : addrIn;
              wrAddrQ <= (cls == ClsToHub) ? HubA : addrIn;
              opQ     <= opIn;
              immQ    <= instr[15:8];
            end
          end
        end
        StRead:  stateQ <= StCalc;
        StCalc:  stateQ <= StWrite;
        StWrite: stateQ <= StDone;
        StDone:  stateQ <= StIdle;
        default: stateQ <= StIdle;
      endcase
    end
  end

  always_comb begin
    ctl.rdEn      = (stateQ == StRead);
    ctl.calcEn    = (stateQ == StCalc);
    ctl.wrEn      = (stateQ == StWrite);
    ctl.carryLoad = accept && !refuse && isFlag && instr[10];
    ctl.carryVal  = (cls == ClsSetFlag);
    ctl.rdAddr    = rdAddrQ;
    ctl.wrAddr    = wrAddrQ;
    ctl.op        = opQ;
    ctl.imm       = immQ;
  end

  assign done    = (stateQ == StDone);
  assign illegal = done && illegalQ;
  assign resAddr = wrAddrQ;

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r9_refusal_is_fast: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> $past(start));

  a_r9_no_write_on_refusal: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> $past(!ctl.wrEn));

endmodule

// File: rtl/scr_regalu.sv
module scr_regalu
  import scr_regalu_pkg::*;
#(
  parameter int RegCount = 96,
  parameter int HubAddr  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [31:0]         instr,
  output logic                done,
  output logic                illegal,
  output logic [7:0]          resByte,
  output logic [AddrBits-1:0] resAddr,
  output logic                carry
);

  ctlBusT ctl;

  scr_regalu_ctrl #(.RegCount(RegCount), .HubAddr(HubAddr)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .instr  (instr),
    .ctl    (ctl),
    .done   (done),
    .illegal(illegal),
    .resAddr(resAddr)
  );

  scr_regalu_dpath #(.RegCount(RegCount)) uDpath (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .resByte(resByte),
    .carry  (carry)
  );

endmodule

// File: tb/tb_scr_regalu.sv
`timescale 1ns/1ps
module tb_scr_regalu;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic        done;
  logic        illegal;
  logic [7:0]  resByte;
  logic [6:0]  resAddr;
  logic        carry;

  int checks = 0;
  int errors = 0;
  int lat;
  logic [7:0] rb;

  scr_regalu dut (
    .clk(clk), .rstN(rstN), .start(start), .instr(instr),
    .done(done), .illegal(illegal), .resByte(resByte),
    .resAddr(resAddr), .carry(carry)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] mk(input logic [4:0] cls, input logic [2:0] op,
                                     input logic [6:0] addr, input logic [7:0] imm);
    return {cls, op, 1'b0, addr, imm, 8'h00};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] ins, output int cyc);
    @(negedge clk);
    instr = ins;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 20) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic readReg(input logic [6:0] a, output logic [7:0] v);
    int c;
    run(mk(5'b00111, 3'd2, a, 8'h00), c);
    v = resByte;
  endtask

  task automatic writeReg(input logic [6:0] a, input logic [7:0] v);
    int c;
    run(mk(5'b00111, 3'd0, a, v), c);
  endtask

  task automatic setCarry(input logic v);
    int c;
    run(v ? 32'h5800_0400 : 32'h6000_0400, c);
  endtask

  task automatic tReset;
    chk("R1 done low", done, 0);
    chk("R1 illegal low", illegal, 0);
    chk("R1 carry zero", carry, 0);
    readReg(7'd52, rb);
    chk("R1 register zero", rb, 8'h00);
  endtask

  task automatic tImmediate;
    run(mk(5'b00111, 3'd0, 7'd52, 8'hA5), lat);
    chk("R10 transfer latency", lat, 4);
    chk("R11 result byte", resByte, 8'hA5);
    chk("R11 result addr", resAddr, 7'd52);
    chk("R2 not illegal", illegal, 0);
    @(negedge clk);
    chk("R10 done single pulse", done, 0);
    readReg(7'd52, rb);
    chk("R2 immediate stored", rb, 8'hA5);
  endtask

  task automatic tLogic;
    setCarry(1'b1);
    run(mk(5'b00111, 3'd3, 7'd52, 8'hFF), lat);
    chk("R3 xor", resByte, 8'h5A);
    run(mk(5'b00111, 3'd4, 7'd52, 8'h0F), lat);
    chk("R3 and", resByte, 8'h0A);
    run(mk(5'b00111, 3'd2, 7'd52, 8'h30), lat);
    chk("R3 or", resByte, 8'h3A);
    chk("R3 carry untouched", carry, 1);
    readReg(7'd52, rb);
    chk("R3 written back", rb, 8'h3A);
  endtask

  task automatic tToHub;
    writeReg(7'd53, 8'h11);
    run(mk(5'b00110, 3'd2, 7'd53, 8'h02), lat);
    chk("R4 result", resByte, 8'h13);
    chk("R11 hub addr", resAddr, 7'd8);
    readReg(7'd8, rb);
    chk("R4 hub loaded", rb, 8'h13);
    readReg(7'd53, rb);
    chk("R4 source kept", rb, 8'h11);
  endtask

  task automatic tFromHub;
    run(mk(5'b00101, 3'd3, 7'd54, 8'hFF), lat);
    chk("R5 result addr", resAddr, 7'd54);
    readReg(7'd54, rb);
    chk("R5 target", rb, 8'hEC);
    readReg(7'd8, rb);
    chk("R5 hub kept", rb, 8'h13);
  endtask

  task automatic tAdd;
    setCarry(1'b0);
    writeReg(7'd55, 8'hF0);
    run(mk(5'b00111, 3'd6, 7'd55, 8'h20), lat);
    chk("R6 add sum", resByte, 8'h10);
    chk("R6 add carry out", carry, 1);
    run(mk(5'b00111, 3'd7, 7'd52, 8'h01), lat);
    chk("R6 addc uses carry", resByte, 8'h3C);
    chk("R6 addc carry out", carry, 0);
    setCarry(1'b1);
    run(mk(5'b00111, 3'd6, 7'd52, 8'h01), lat);
    chk("R6 add ignores carry in", resByte, 8'h3D);
    chk("R6 add clears carry", carry, 0);
  endtask

  task automatic tShift;
    writeReg(7'd52, 8'h81);
    setCarry(1'b0);
    run(mk(5'b00111, 3'd1, 7'd52, 8'hFF), lat);
    chk("R7 shl result", resByte, 8'h02);
    chk("R7 shl carry", carry, 1);
    run(mk(5'b00111, 3'd1, 7'd52, 8'h00), lat);
    chk("R7 shl chained", resByte, 8'h05);
    chk("R7 shl carry clear", carry, 0);
    setCarry(1'b1);
    run(mk(5'b00111, 3'd5, 7'd52, 8'h00), lat);
    chk("R7 shr result", resByte, 8'h82);
    chk("R7 shr carry", carry, 1);
  endtask

  task automatic tFlags;
    run(32'h6000_0400, lat);
    chk("R8 clear carry", carry, 0);
    chk("R10 flag latency", lat, 1);
    run(32'h5800_0400, lat);
    chk("R8 set carry", carry, 1);
    run(32'h6000_0000, lat);
    chk("R8 no select keeps carry", carry, 1);
    chk("R8 not illegal", illegal, 0);
    readReg(7'd52, rb);
    chk("R8 register untouched", rb, 8'h82);
  endtask

  task automatic tIllegal;
    setCarry(1'b1);
    run(32'h2000_0000, lat);
    chk("R9 bad class flag", illegal, 1);
    chk("R9 bad class latency", lat, 1);
    run(mk(5'b00111, 3'd0, 7'd100, 8'h55), lat);
    chk("R9 bad address flag", illegal, 1);
    run(mk(5'b00110, 3'd0, 7'd52, 8'h77), lat);
    chk("R9 cross immediate flag", illegal, 1);
    chk("R9 carry unchanged", carry, 1);
    readReg(7'd8, rb);
    chk("R9 hub not written", rb, 8'h13);
    run(mk(5'b00101, 3'd0, 7'd53, 8'h77), lat);
    chk("R9 from-hub immediate flag", illegal, 1);
    readReg(7'd53, rb);
    chk("R9 target not written", rb, 8'h11);
  endtask

  task automatic tBusy;
    int c;
    @(negedge clk);
    instr = mk(5'b00111, 3'd0, 7'd54, 8'h3C);
    start = 1'b1;
    @(negedge clk);
    instr = mk(5'b00111, 3'd0, 7'd53, 8'h99);
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    c = 3;
    while (!done && c < 20) begin
      @(negedge clk);
      c++;
    end
    chk("R10 busy first completes", c, 4);
    chk("R10 busy first target", resAddr, 7'd54);
    @(negedge clk);
    chk("R10 no second done", done, 0);
    readReg(7'd53, rb);
    chk("R10 start ignored while busy", rb, 8'h11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tImmediate();
    tLogic();
    tToHub();
    tFromHub();
    tAdd();
    tShift();
    tFlags();
    tIllegal();
    tBusy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule